// File: doc/BRIEF.md
# Transmit Inter-Frame Gap Timer

This block sets the idle time between back-to-back frames on a byte-wide Ethernet transmit path. A frame transmitter asks it whether a new frame may begin (`start_ok`), reports the first byte of each frame with `frame_start`, and reports the last byte with a one-cycle `frame_end` strobe. After each `frame_end` the block counts idle byte clocks. One byte clock is one idle cycle of 8 bit times. `start_ok` stays low until the effective gap has passed.

Software programs a gap length through a 32-bit register. Only the low byte of that register is implemented. A separate configuration register outside the block supplies the enable bit `gap_adj_en`. When the enable is clear, or the programmed value is below the floor of 12 idle cycles (96 bit times), the block uses 12. The effective gap is captured when a frame ends, so a register write made during a gap takes effect from the next gap on.

The controller is a three-state machine:
- READY: a start is allowed.
- BUSY: a frame is being sent.
- GAP: the idle count is running.

It has four transitions:
- READY→BUSY on `frame_start`.
- Any state→GAP on `frame_end`. This transition has priority over the others and also restarts a gap that is already running.
- GAP→READY once the captured count is reached.
- BUSY and GAP ignore `frame_start`.

Top module: `tx_ifg_timer`

## Requirements
- R1: Register bits [7:0] are a read/write gap value that resets to 0; `reg_rd_data` always shows the stored value.
- R2: Register bits [31:8] ignore writes and always read as zero.
- R3: With `gap_adj_en` high and a programmed value of 12 or more, the effective gap equals the programmed value (up to 255).
- R4: With `gap_adj_en` high and a programmed value from 0 to 11, the effective gap is 12.
- R5: With `gap_adj_en` low, the effective gap is 12 whatever value is programmed.
- R6: After reset `start_ok` is high (state READY), so the first frame may begin at once.
- R7: A `frame_start` while `start_ok` is high drives `start_ok` low from the next cycle (READY→BUSY). It stays low while the frame is in progress.
- R8: After the clock edge that samples `frame_end`, `start_ok` is low for exactly G cycles, where G is the effective gap. It is high in the cycle after those G idle cycles (GAP→READY).
- R9: The gap value and the enable are captured at `frame_end`. A register write during a running gap does not change that gap and applies to the next one.
- R10: A `frame_end` that arrives during GAP restarts the count with a newly captured effective gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the gap register |
| reg_wr_data | input | 32 | Write data; only bits [7:0] are stored |
| reg_rd_data | output | 32 | Register read value; bits [31:8] are zero |
| gap_adj_en | input | 1 | Enable for the programmed gap, from an external configuration register |
| frame_start | input | 1 | Transmitter begins a frame |
| frame_end | input | 1 | One-cycle strobe on the last byte of a frame |
| start_ok | output | 1 | High when a new frame may start |

## Verification
A wrong internal state shows up directly in the length of the low pulse on `start_ok` after a `frame_end`. A gap value latched from the wrong cycle or clamped wrongly, or a counter that is off by one, makes that pulse one or more cycles too long or too short. The error is visible within at most 256 cycles of the strobe. A state machine stuck in BUSY or GAP leaves `start_ok` low indefinitely. A missed READY→BUSY transition leaves `start_ok` high in the cycle right after `frame_start`. A faulty register is visible immediately on `reg_rd_data`, and also in the next gap length.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_GAP   = 2'd2
    } ifg_state_t;
endpackage

// File: rtl/ifg_cfg_reg.sv
module ifg_cfg_reg #(
    parameter int DATA_W = 32,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GAP_W-1:0]  wr_gap,
    output logic [GAP_W-1:0]  gap_val,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - GAP_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_val <= '0;
        end else if (wr_en) begin
            gap_val <= wr_gap;
        end
    end

    // upper bits are not stored and read back as zero
    assign rd_data = {{PAD_W{1'b0}}, gap_val};
endmodule

// File: rtl/ifg_gap_clamp.sv
module ifg_gap_clamp #(
    parameter int GAP_W   = 8,
    parameter int MIN_GAP = 12
) (
    input  logic             adj_en,
    input  logic [GAP_W-1:0] gap_val,
    output logic [GAP_W-1:0] eff_gap
);
    localparam logic [GAP_W-1:0] FLOOR = GAP_W'(MIN_GAP);

    always_comb begin
        if (adj_en && (gap_val >= FLOOR)) begin
            eff_gap = gap_val;
        end else begin
            eff_gap = FLOOR;
        end
    end
endmodule

// File: rtl/ifg_gap_fsm.sv
module ifg_gap_fsm
    import ifg_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [GAP_W-1:0] eff_gap,
    output logic             start_ok
);
    ifg_state_t       state_q, state_d;
    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] gap_lat_q;
    logic             gap_done;

    assign gap_done = (cnt_q == gap_lat_q - GAP_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (frame_end) begin
            state_d = ST_GAP;
        end else begin
            unique case (state_q)
                ST_READY: if (frame_start) state_d = ST_BUSY;
                ST_BUSY:  state_d = ST_BUSY;
                ST_GAP:   if (gap_done) state_d = ST_READY;
                default:  state_d = ST_READY;
            endcase
        end
    end

    // idle counter and gap capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            gap_lat_q <= '0;
        end else if (frame_end) begin
            cnt_q     <= '0;
            gap_lat_q <= eff_gap;
        end else if (state_q == ST_GAP) begin
            cnt_q <= cnt_q + GAP_W'(1);
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_READY: start_ok = 1'b1;
            ST_BUSY:  start_ok = 1'b0;
            ST_GAP:   start_ok = 1'b0;
            default:  start_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/tx_ifg_timer.sv
module tx_ifg_timer #(
    parameter int DATA_W  = 32,
    parameter int GAP_W   = 8,
    parameter int MIN_GAP = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              gap_adj_en,
    input  logic              frame_start,
    input  logic              frame_end,
    output logic              start_ok
);
    logic [GAP_W-1:0] gap_val;
    logic [GAP_W-1:0] eff_gap;

    ifg_cfg_reg #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_gap  (reg_wr_data[GAP_W-1:0]),
        .gap_val (gap_val),
        .rd_data (reg_rd_data)
    );

    ifg_gap_clamp #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_clamp (
        .adj_en  (gap_adj_en),
        .gap_val (gap_val),
        .eff_gap (eff_gap)
    );

    ifg_gap_fsm #(.GAP_W(GAP_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .eff_gap     (eff_gap),
        .start_ok    (start_ok)
    );
endmodule

// File: rtl/tx_ifg_timer_sva.sv
module tx_ifg_timer_sva #(
    parameter int DATA_W  = 32,
    parameter int GAP_W   = 8,
    parameter int MIN_GAP = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] reg_rd_data,
    input logic              frame_start,
    input logic              frame_end,
    input logic              start_ok
);
    // count of low start_ok cycles since the last frame_end
    logic [GAP_W:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (frame_end) begin
            low_run <= '0;
        end else if (!start_ok && !(&low_run)) begin
            low_run <= low_run + 1'b1;
        end
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[DATA_W-1:GAP_W] == '0);

    a_r8_low_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !start_ok);

    a_r7_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && frame_start && !frame_end) |=> !start_ok);

    a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_ok) |-> (low_run >= (GAP_W+1)'(MIN_GAP)));
endmodule

bind tx_ifg_timer tx_ifg_timer_sva #(
    .DATA_W(DATA_W), .GAP_W(GAP_W), .MIN_GAP(MIN_GAP)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd_data (reg_rd_data),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .start_ok    (start_ok)
);

// File: tb/tx_ifg_timer_tb_top.sv
`timescale 1ns/1ps
module tx_ifg_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        gap_adj_en = 1'b0;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic        start_ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tx_ifg_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .gap_adj_en  (gap_adj_en),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .start_ok    (start_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    function automatic int model_gap(input int v, input bit en);
        return (en && v >= 12) ? v : 12;
    endfunction

    // pulse frame_end, then count the cycles in which start_ok is low
    task automatic measure_gap(output int low_cnt);
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        low_cnt = 0;
        while (!start_ok && low_cnt < 400) begin
            low_cnt++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6, R1 reset state
        check("R6 start_ok after reset", int'(start_ok), 1);
        check("R1 register resets to 0", int'(reg_rd_data), 0);

        // R1/R2 register access
        reg_write(32'hA5C3_E71B);
        check("R1 low byte stored", int'(reg_rd_data[7:0]), 8'h1B);
        check("R2 upper bits zero", int'(reg_rd_data[31:8]), 0);
        reg_write(32'hFFFF_FF00);
        check("R2 upper bits ignore writes", int'(reg_rd_data), 0);

        // R7 frame start
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check("R7 start_ok low after frame_start", int'(start_ok), 0);
        repeat (20) @(negedge clk);
        check("R7 start_ok low during frame", int'(start_ok), 0);
        gap_adj_en = 1'b1;
        measure_gap(g);
        check("R7 gap after frame", g, 12);

        // sweep programmed values, enable on and off (R3, R4, R5, R8)
        for (int en = 0; en < 2; en++) begin
            gap_adj_en = en[0];
            for (int v = 0; v < 48; v++) begin
                reg_write(32'(v));
                measure_gap(g);
                if (en == 0)
                    check("R5 disabled gap", g, model_gap(v, 1'b0));
                else if (v < 12)
                    check("R4 clamped gap", g, model_gap(v, 1'b1));
                else
                    check("R3 programmed gap", g, model_gap(v, 1'b1));
                check("R8 high after gap", int'(start_ok), 1);
            end
            for (int v = 250; v < 256; v++) begin
                reg_write(32'(v));
                measure_gap(g);
                check(en ? "R3 large gap" : "R5 large disabled", g,
                      model_gap(v, en[0]));
            end
        end

        // R9 write during a running gap affects only the next gap
        gap_adj_en = 1'b1;
        reg_write(32'd30);
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        reg_wr_en = 1'b1;
        reg_wr_data = 32'd15;
        g = 1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        gap_adj_en = 1'b0;
        while (!start_ok && g < 400) begin
            g++;
            @(negedge clk);
        end
        check("R9 running gap unchanged", g, 30);
        gap_adj_en = 1'b1;
        measure_gap(g);
        check("R9 next gap uses new value", g, 15);

        // R10 frame_end during gap restarts count
        reg_write(32'd40);
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 low mid gap", int'(start_ok), 0);
        reg_write(32'd20);
        measure_gap(g);
        check("R10 restarted gap", g, 20);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule